// File: doc/BRIEF.md
# Palette DAC Host Register Port

This block is the host-side register front end of a palette digital-to-analog converter. The host writes single bytes into eight direct registers. The 3-bit register address is built from a bank-select input, taken from bit 0 of a DAC control register elsewhere in the chip, as the high bit, and a 2-bit offset as the low bits. Through these registers the host loads a 256-entry colour lookup table and a bank of 256 indirect byte registers.

A palette entry takes three data writes in the order red, green, blue. The first two bytes are held in the block. The third write commits all three to the entry selected by the write index, with alpha fixed at 255, and then advances the index by one. The indirect bank is reached through a low/high index pair and a data port. A few indirect registers are decoded into a pixel-format flag and clock-synthesiser parameters. The display pipeline reads the palette and the indirect bank through asynchronous read ports.

Top module: `ramdac_port`

## Requirements
- R1: After reset, the palette write index is 0, the component counter is 0, the pixel mask is 0xFF, the mask warning is 0 and every indirect register reads 0.
- R2: A write takes effect only when `wr_en` and `wr_byte` are both 1. The register address is {`bank_sel`, `wr_off`}. A write with `wr_byte`=0 changes no register.
- R3: A write to address 0 loads the palette write index from the data and clears the component counter to 0.
- R4: Writes to address 1 step the component counter 0→1→2 and hold red, then green. The write made with the counter at 2 commits {red, green, data} to the indexed entry. The read port then returns {0xFF, red, green, blue}, from the cycle after that edge. Before the commit edge the entry keeps its old value.
- R5: After each commit the write index increments by one, wrapping from 255 to 0, and the component counter returns to 0.
- R6: A write to address 2 stores the pixel mask. Any value other than 0xFF sets `mask_warn`, which stays set until reset.
- R7: Address 4 loads index low and address 5 loads index high. A write to address 6 stores the data into indirect register `low` when high is 0, and is discarded when high is not 0.
- R8: `fmt_8bpp` is 1 exactly when indirect register 0x0A holds 3.
- R9: `pll_en` is bit 0 of indirect register 0x02. While it is 1: `pll_mult` = 8 >> reg0x20[7:6], `vco_div` = reg0x20[5:0] + 65, and `ref_div` = reg0x21[4:0] × `pll_mult`. While it is 0, these three outputs are 0.
- R10: Writes to address 3 (palette read address) and address 7 (index control) change no observable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_byte | input | 1 | 1 = byte-sized access; wider accesses are ignored |
| bank_sel | input | 1 | Register address bit 2 |
| wr_off | input | 2 | Register address bits 1:0 |
| wr_data | input | 8 | Write data |
| pal_rd_addr | input | 8 | Palette read port address |
| pal_rd_rgba | output | 32 | {alpha, red, green, blue} of the addressed entry |
| ind_rd_addr | input | 8 | Indirect register read address |
| ind_rd_data | output | 8 | Indirect register contents |
| pal_index | output | 8 | Current palette write index |
| comp_cnt | output | 2 | Colour components received for the pending entry |
| pix_mask | output | 8 | Stored pixel mask |
| mask_warn | output | 1 | Sticky flag: a mask other than 0xFF was written |
| fmt_8bpp | output | 1 | Pixel format selects 8 bits per pixel |
| pll_en | output | 1 | Clock synthesiser enable |
| pll_mult | output | 4 | Multiplier field |
| vco_div | output | 8 | VCO divisor |
| ref_div | output | 8 | Reference divisor |

## Verification
The display pipeline can read an entry in the same cycle that the third colour byte commits to it. The bench aims `pal_rd_addr` at the pending index and drives the blue write. Just before that edge it expects the old colour on the read port, and just after the edge it expects the new one. The second collision is the index wrap: a commit at index 255 must land in entry 255 and leave the index at 0. The bench checks both the committed entry and the index.

// File: rtl/ramdac_port.sv
module ramdac_port #(
  parameter int PAL_AW = 8,
  parameter int IND_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic              bank_sel,
  input  logic [1:0]        wr_off,
  input  logic [7:0]        wr_data,
  input  logic [PAL_AW-1:0] pal_rd_addr,
  output logic [31:0]       pal_rd_rgba,
  input  logic [IND_AW-1:0] ind_rd_addr,
  output logic [7:0]        ind_rd_data,
  output logic [PAL_AW-1:0] pal_index,
  output logic [1:0]        comp_cnt,
  output logic [7:0]        pix_mask,
  output logic              mask_warn,
  output logic              fmt_8bpp,
  output logic              pll_en,
  output logic [3:0]        pll_mult,
  output logic [7:0]        vco_div,
  output logic [7:0]        ref_div
);
  localparam int PAL_N = 1 << PAL_AW;
  localparam int IND_N = 1 << IND_AW;

  logic [23:0] pal_mem [PAL_N];
  logic [7:0]  ind_reg [IND_N];
  logic [7:0]  red_q, grn_q, idx_lo, idx_hi;
  logic [15:0] ind_full;
  logic [2:0]  reg_sel;
  logic        hit, commit, ind_ok;

  assign reg_sel  = {bank_sel, wr_off};
  assign hit      = wr_en & wr_byte;
  assign commit   = hit && reg_sel == 3'd1 && comp_cnt == 2'd2;
  assign ind_full = {idx_hi, idx_lo};
  assign ind_ok   = (ind_full >> IND_AW) == 16'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pal_index <= '0;
      comp_cnt  <= 2'd0;
      red_q     <= 8'd0;
      grn_q     <= 8'd0;
      idx_lo    <= 8'd0;
      idx_hi    <= 8'd0;
      pix_mask  <= 8'hFF;
      mask_warn <= 1'b0;
    end else if (hit) begin
      case (reg_sel)
        3'd0: begin
          pal_index <= wr_data[PAL_AW-1:0];
          comp_cnt  <= 2'd0;
        end
        3'd1: begin
          case (comp_cnt)
            2'd0: begin red_q <= wr_data; comp_cnt <= 2'd1; end
            2'd1: begin grn_q <= wr_data; comp_cnt <= 2'd2; end
            default: begin
              comp_cnt  <= 2'd0;
              pal_index <= pal_index + 1'b1;
            end
          endcase
        end
        3'd2: begin
          pix_mask <= wr_data;
          if (wr_data != 8'hFF) mask_warn <= 1'b1;
        end
        3'd4: idx_lo <= wr_data;
        3'd5: idx_hi <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (commit) pal_mem[pal_index] <= {red_q, grn_q, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < IND_N; i++) ind_reg[i] <= 8'd0;
    end else if (hit && reg_sel == 3'd6 && ind_ok) begin
      ind_reg[ind_full[IND_AW-1:0]] <= wr_data;
    end
  end

  assign pal_rd_rgba = {8'hFF, pal_mem[pal_rd_addr]};
  assign ind_rd_data = ind_reg[ind_rd_addr];

  logic [7:0] clk_ctl, pix_fmt, fb_m, fb_n;
  assign clk_ctl = ind_reg[IND_AW'(8'h02)];
  assign pix_fmt = ind_reg[IND_AW'(8'h0A)];
  assign fb_m    = ind_reg[IND_AW'(8'h20)];
  assign fb_n    = ind_reg[IND_AW'(8'h21)];

  assign fmt_8bpp = pix_fmt == 8'd3;
  assign pll_en   = clk_ctl[0];
  assign pll_mult = pll_en ? (4'd8 >> fb_m[7:6]) : 4'd0;
  assign vco_div  = pll_en ? ({2'b00, fb_m[5:0]} + 8'd65) : 8'd0;
  assign ref_div  = pll_en ? ({3'b000, fb_n[4:0]} * {4'b0000, pll_mult}) : 8'd0;
endmodule

// File: rtl/ramdac_port_chk.sv
module ramdac_port_chk #(
  parameter int PAL_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_byte,
  input logic              bank_sel,
  input logic [1:0]        wr_off,
  input logic [7:0]        wr_data,
  input logic [PAL_AW-1:0] pal_index,
  input logic [1:0]        comp_cnt,
  input logic [7:0]        pix_mask,
  input logic              mask_warn
);
  logic       hit;
  logic [2:0] sel;
  assign hit = wr_en && wr_byte;
  assign sel = {bank_sel, wr_off};

  a_r2_wide_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte) |=> ($stable(pal_index) && $stable(comp_cnt) && $stable(pix_mask)));

  a_r3_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == 3'd0) |=> (comp_cnt == 2'd0 && pal_index == $past(wr_data[PAL_AW-1:0])));

  a_r4_comp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == 3'd1 && comp_cnt != 2'd2) |=>
      (comp_cnt == $past(comp_cnt) + 2'd1 && $stable(pal_index)));

  a_r4_comp_range: assert property (@(posedge clk) disable iff (!rst_n)
    comp_cnt != 2'd3);

  a_r5_commit_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == 3'd1 && comp_cnt == 2'd2) |=>
      (comp_cnt == 2'd0 && pal_index == $past(pal_index) + 1'b1));

  a_r6_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mask_warn |=> mask_warn);

  a_r6_warn_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == 3'd2 && wr_data != 8'hFF) |=> (mask_warn && pix_mask == $past(wr_data)));
endmodule

bind ramdac_port ramdac_port_chk #(.PAL_AW(PAL_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
  .bank_sel(bank_sel), .wr_off(wr_off), .wr_data(wr_data),
  .pal_index(pal_index), .comp_cnt(comp_cnt), .pix_mask(pix_mask),
  .mask_warn(mask_warn)
);

// File: tb/ramdac_port_bench.sv
module ramdac_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_byte = 1'b0, bank_sel = 1'b0;
  logic [1:0]  wr_off = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  pal_rd_addr = 8'd0, ind_rd_addr = 8'd0;
  logic [31:0] pal_rd_rgba;
  logic [7:0]  ind_rd_data, pal_index, pix_mask, vco_div, ref_div;
  logic [1:0]  comp_cnt;
  logic        mask_warn, fmt_8bpp, pll_en;
  logic [3:0]  pll_mult;

  ramdac_port u_ramdac_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
    .bank_sel(bank_sel), .wr_off(wr_off), .wr_data(wr_data),
    .pal_rd_addr(pal_rd_addr), .pal_rd_rgba(pal_rd_rgba),
    .ind_rd_addr(ind_rd_addr), .ind_rd_data(ind_rd_data),
    .pal_index(pal_index), .comp_cnt(comp_cnt), .pix_mask(pix_mask),
    .mask_warn(mask_warn), .fmt_8bpp(fmt_8bpp), .pll_en(pll_en),
    .pll_mult(pll_mult), .vco_div(vco_div), .ref_div(ref_div)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [23:0] m_pal [256];
  bit          m_val [256];
  logic [7:0]  m_ind [256];
  logic [7:0]  m_idx, m_r, m_g, m_lo, m_hi, m_mask;
  logic [1:0]  m_comp;
  logic        m_warn;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] derived_exp();
    logic [7:0] c = m_ind[8'h02], f = m_ind[8'h0A], m = m_ind[8'h20], n = m_ind[8'h21];
    logic [3:0] mu = c[0] ? (4'd8 >> m[7:6]) : 4'd0;
    logic [7:0] v = c[0] ? ({2'b0, m[5:0]} + 8'd65) : 8'd0;
    logic [7:0] r = c[0] ? ({3'b0, n[4:0]} * {4'b0, mu}) : 8'd0;
    return {5'd0, (f == 8'd3), c[0], mu, v, r};
  endfunction

  task automatic model_reset();
    m_idx = 0; m_comp = 0; m_r = 0; m_g = 0; m_lo = 0; m_hi = 0;
    m_mask = 8'hFF; m_warn = 0;
    for (int i = 0; i < 256; i++) begin m_ind[i] = 0; m_val[i] = 0; end
  endtask

  task automatic wr(bit byt, logic [2:0] a, logic [7:0] d);
    wr_en = 1; wr_byte = byt; bank_sel = a[2]; wr_off = a[1:0]; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 0;
    if (byt) begin
      case (a)
        3'd0: begin m_idx = d; m_comp = 0; end
        3'd1: case (m_comp)
          2'd0: begin m_r = d; m_comp = 1; end
          2'd1: begin m_g = d; m_comp = 2; end
          default: begin
            m_pal[m_idx] = {m_r, m_g, d}; m_val[m_idx] = 1;
            m_idx = m_idx + 1; m_comp = 0;
          end
        endcase
        3'd2: begin m_mask = d; if (d != 8'hFF) m_warn = 1; end
        3'd4: m_lo = d;
        3'd5: m_hi = d;
        3'd6: if (m_hi == 0) m_ind[m_lo] = d;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic chk_state(string req);
    chk(req, {pal_index, 6'd0, comp_cnt, pix_mask, 7'd0, mask_warn},
             {m_idx, 6'd0, m_comp, m_mask, 7'd0, m_warn});
    chk(req, {5'd0, fmt_8bpp, pll_en, pll_mult, vco_div, ref_div}, derived_exp());
  endtask

  task automatic chk_pal(string req, logic [7:0] a);
    pal_rd_addr = a; #1;
    chk(req, pal_rd_rgba, {8'hFF, m_pal[a]});
  endtask

  task automatic chk_ind(string req, logic [7:0] a);
    ind_rd_addr = a; #1;
    chk(req, {24'd0, ind_rd_data}, {24'd0, m_ind[a]});
  endtask

  task automatic ind_wr(logic [7:0] a, logic [7:0] d);
    wr(1, 3'd5, 8'd0); wr(1, 3'd4, a); wr(1, 3'd6, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);

    chk_state("R1 reset");
    chk_ind("R1 reset ind", 8'h0A);
    chk_ind("R1 reset ind", 8'hFF);

    // R3 + R4 + R5 basic entry
    wr(1, 3'd0, 8'h10);
    chk_state("R3 index load");
    wr(1, 3'd1, 8'hA1); chk_state("R4 red held");
    wr(1, 3'd1, 8'hB2); chk_state("R4 green held");
    wr(1, 3'd1, 8'hC3); chk_state("R5 increment");
    chk_pal("R4 commit", 8'h10);

    // R3: address write mid-entry clears the counter
    wr(1, 3'd1, 8'h11);
    wr(1, 3'd0, 8'h20);
    chk_state("R3 counter cleared");
    wr(1, 3'd1, 8'h01); wr(1, 3'd1, 8'h02); wr(1, 3'd1, 8'h03);
    chk_pal("R3 fresh entry", 8'h20);

    // R4 same-cycle commit vs read of the same entry
    wr(1, 3'd0, 8'h20);
    wr(1, 3'd1, 8'h55); wr(1, 3'd1, 8'h66);
    pal_rd_addr = 8'h20;
    wr_en = 1; wr_byte = 1; bank_sel = 0; wr_off = 2'd1; wr_data = 8'h77;
    #1;
    chk("R4 old before edge", pal_rd_rgba, 32'hFF010203);
    @(posedge clk); #1;
    wr_en = 0;
    chk("R4 new after edge", pal_rd_rgba, 32'hFF556677);
    m_pal[8'h20] = 24'h556677; m_idx = 8'h21; m_comp = 0;
    @(negedge clk);

    // R5 wrap
    wr(1, 3'd0, 8'hFF);
    wr(1, 3'd1, 8'h9A); wr(1, 3'd1, 8'hBC); wr(1, 3'd1, 8'hDE);
    chk_state("R5 wrap");
    chk_pal("R5 wrap entry", 8'hFF);

    // R2 wide writes ignored
    wr(0, 3'd0, 8'h44); wr(0, 3'd2, 8'h00); wr(0, 3'd1, 8'h12);
    chk_state("R2 wide ignored");

    // R10 read address and index control
    wr(1, 3'd1, 8'h31);
    wr(1, 3'd3, 8'h80); wr(1, 3'd7, 8'h01);
    chk_state("R10 no effect");

    // R6
    wr(1, 3'd2, 8'hFF); chk_state("R6 mask FF no warn");
    wr(1, 3'd2, 8'h0F); chk_state("R6 warn set");
    wr(1, 3'd2, 8'hFF); chk_state("R6 warn sticky");

    // R7 high nonzero discarded
    wr(1, 3'd5, 8'h01); wr(1, 3'd4, 8'h0A); wr(1, 3'd6, 8'h03);
    chk_ind("R7 high discard", 8'h0A);
    chk_state("R8 not 8bpp");

    // R8, R9
    ind_wr(8'h0A, 8'h03); chk_state("R8 8bpp");
    ind_wr(8'h20, 8'hC5); ind_wr(8'h21, 8'h1F);
    chk_state("R9 pll off");
    ind_wr(8'h02, 8'h01); chk_state("R9 pll on");
    ind_wr(8'h20, 8'h3F); chk_state("R9 mult 8");
    ind_wr(8'h20, 8'h40); ind_wr(8'h21, 8'h07); chk_state("R9 mult 4");
    ind_wr(8'h0A, 8'h04); chk_state("R8 other format");

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      logic [2:0] a = 3'($urandom % 8);
      logic [7:0] d = 8'($urandom);
      bit byt = ($urandom % 10) != 0;
      if (a == 3'd5 && ($urandom % 4) != 0) d = 8'd0;
      if (a == 3'd2 && ($urandom % 2) != 0) d = 8'hFF;
      if (a == 3'd4 && ($urandom % 3) == 0) d = 8'h02 + 8'($urandom % 2) * 8'h1E;
      wr(byt, a, d);
      chk_state("R2 R3 R5 R6 random");
      if (it % 8 == 0) begin
        logic [7:0] p = 8'($urandom);
        if (m_val[p]) chk_pal("R4 random", p);
        chk_ind("R7 random", 8'($urandom));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule